// File: doc/BRIEF.md
# Micro-Frame Schedule Walker

This block steers a host controller through two linked lists held in memory during every micro-frame. When a micro-frame begins it takes the frame index, picks one element of a frame-pointer array from it, and then walks the chain of periodic descriptors that the element leads to. A descriptor is handed downstream through an execute handshake. Its first word, the link pointer, is then read to find the next descriptor.

A link pointer with its terminate flag set ends the periodic walk. The walker then moves to the asynchronous list, starting from a head pointer register, and keeps going there until that list terminates or the micro-frame closes. An end-of-micro-frame strobe does not cut off a read or an execute that is already under way. The walk stops at the next descriptor boundary, and the walker waits for the next start strobe.

The memory side is a plain read request and response pair: the address is held until the response is valid. Descriptor contents are not interpreted here. The downstream engine only receives the descriptor address and a flag that names the list it came from.

Top module: `sched_walker`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to idle. After that edge rd_req_o and exec_valid_o are both 0.
- R2: On a start strobe with the periodic list enabled, the first read address is built from three parts. Bits 31:12 are per_base_i[31:12], bits 11:2 are frame_idx_i[12:3], and bits 1:0 are 0. frame_idx_i[2:0], frame_idx_i[13] and per_base_i[11:0] have no effect.
- R3: The frame index is captured on the start strobe. A change of frame_idx_i while that read is waiting leaves rd_addr_o unchanged.
- R4: Within one micro-frame, every periodic descriptor (exec_async_o=0) is presented before any asynchronous one (exec_async_o=1).
- R5: A pointer word has its terminate flag in bit 0. The descriptor it names sits at the word with bits 4:0 cleared, and that descriptor's link pointer is read from that same address.
- R6: A periodic pointer word (frame element or link) with bit 0 set hands over at once to the asynchronous list. The first asynchronous descriptor is async_head_i with bits 4:0 cleared.
- R7: A start strobe with the periodic list disabled skips the frame element and begins at the asynchronous head.
- R8: The asynchronous list is followed until a link with bit 0 set is read. If async_en_i is 0, or async_head_i[0] is 1, when the asynchronous list would begin, the block goes idle instead.
- R9: rd_req_o stays high with a stable address until rd_valid_i is seen. exec_valid_o stays high with stable address and list flag until exec_done_i is seen. The two are never high together.
- R10: After uframe_end_i, a read or execute already in progress completes. No further descriptor is presented or read, and the block goes idle.
- R11: A start strobe that arrives while the block is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_base_i | input | 32 | Base of the frame pointer array (upper 20 bits used) |
| frame_idx_i | input | 14 | Micro-frame index counter |
| per_en_i | input | 1 | Periodic list enable |
| async_en_i | input | 1 | Asynchronous list enable |
| async_head_i | input | 32 | Asynchronous list head pointer, bit 0 = terminate |
| uframe_start_i | input | 1 | Micro-frame start strobe |
| uframe_end_i | input | 1 | Micro-frame end strobe |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data |
| exec_valid_o | output | 1 | Descriptor ready for execution |
| exec_addr_o | output | 32 | Address of the descriptor to execute |
| exec_async_o | output | 1 | 1 when the descriptor comes from the asynchronous list |
| exec_done_i | input | 1 | Descriptor execution finished |

## Verification
A mixed chain of three periodic and two asynchronous descriptors, with junk in the pointer type bits, checks the ordering between the lists and the alignment of pointers. Several base and index pairs, including all-ones and values where only ignored bits are set, show which bits build the frame element address. Single-step cases cover the periodic list turned off, the asynchronous list turned off, and a terminated asynchronous head, which tell apart the three ways a micro-frame can move on or stop. A circular asynchronous list, cut by an end strobe during an execute and then during a read, shows that the work in flight completes and nothing follows it. A second start in mid-walk and an index change during a slow read show that neither disturbs the traversal.

// File: rtl/sched_walk_pkg.sv
// Shared types of the schedule walker.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sched_walk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LIST_RD,
        ST_PER_RUN,
        ST_PER_LINK,
        ST_ASY_RUN,
        ST_ASY_LINK
    } walk_state_e;
endpackage

// File: rtl/sched_fl_addr.sv
// Builds the frame pointer array element address from the upper base bits
// and the frame index field. The result is always dword aligned.
// Assumes: IDX_FIELD_W + 2 == PAGE_LSB, so the pieces fill ADDR_W exactly.
module sched_fl_addr #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    localparam int IDX_FIELD_W = PAGE_LSB - 2
) (
    input  logic [ADDR_W-PAGE_LSB-1:0] base_hi_i,
    input  logic [IDX_FIELD_W-1:0]     idx_field_i,
    output logic [ADDR_W-1:0]          addr_o
);
    // concatenate the base page, the index field and a zero byte offset
    always_comb begin
        addr_o = {base_hi_i, idx_field_i, 2'b00};
    end
endmodule

// File: rtl/sched_link_dec.sv
// Splits a pointer word into its terminate flag and its aligned target address.
// Assumes: bit 0 is the terminate flag; bits below ALIGN_BITS carry no address.
module sched_link_dec #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              term_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic ptr_unused;
    assign ptr_unused = ^ptr_i[ALIGN_BITS-1:1];

    // pick the flag and clear the low address bits
    always_comb begin
        term_o = ptr_i[0];
        addr_o = {ptr_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
endmodule

// File: rtl/sched_walk_fsm.sv
// Sequencer of the walk: frame element read, periodic run/link steps, then
// asynchronous run/link steps, with end-of-micro-frame stop at descriptor bounds.
// Assumes: pointer words arrive decoded (flag + aligned address) from outside.
module sched_walk_fsm
    import sched_walk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_en_i,
    input  logic              async_en_i,
    input  logic              uf_start_i,
    input  logic              uf_end_i,
    input  logic [ADDR_W-1:0] fl_addr_i,
    input  logic              head_term_i,
    input  logic [ADDR_W-1:0] head_addr_i,
    input  logic              rd_valid_i,
    input  logic              rd_term_i,
    input  logic [ADDR_W-1:0] rd_next_i,
    input  logic              exec_done_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              exec_valid_o,
    output logic [ADDR_W-1:0] exec_addr_o,
    output logic              exec_async_o
);
    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] fl_addr_q;
    logic [ADDR_W-1:0] cur_q, cur_d;
    logic              stop_q;
    logic              stop_now;
    logic              rd_fire;
    logic              ex_fire;

    // handshake completions and the pending stop condition
    always_comb begin
        rd_req_o     = (state_q == ST_LIST_RD) || (state_q == ST_PER_LINK) ||
                       (state_q == ST_ASY_LINK);
        exec_valid_o = (state_q == ST_PER_RUN) || (state_q == ST_ASY_RUN);
        exec_async_o = (state_q == ST_ASY_RUN);
        rd_addr_o    = (state_q == ST_LIST_RD) ? fl_addr_q : cur_q;
        exec_addr_o  = cur_q;
        rd_fire      = rd_req_o && rd_valid_i;
        ex_fire      = exec_valid_o && exec_done_i;
        stop_now     = stop_q || uf_end_i;
    end

    // next-state and next-descriptor selection
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                if (uf_start_i) begin
                    if (per_en_i) begin
                        state_d = ST_LIST_RD;
                    end else if (async_en_i && !head_term_i) begin
                        state_d = ST_ASY_RUN;
                        cur_d   = head_addr_i;
                    end
                end
            end
            ST_LIST_RD, ST_PER_LINK: begin
                if (rd_fire) begin
                    if (stop_now) begin
                        state_d = ST_IDLE;
                    end else if (!rd_term_i) begin
                        state_d = ST_PER_RUN;
                        cur_d   = rd_next_i;
                    end else if (async_en_i && !head_term_i) begin
                        state_d = ST_ASY_RUN;
                        cur_d   = head_addr_i;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PER_RUN: begin
                if (ex_fire) state_d = stop_now ? ST_IDLE : ST_PER_LINK;
            end
            ST_ASY_RUN: begin
                if (ex_fire) state_d = stop_now ? ST_IDLE : ST_ASY_LINK;
            end
            ST_ASY_LINK: begin
                if (rd_fire) begin
                    if (stop_now || rd_term_i) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_ASY_RUN;
                        cur_d   = rd_next_i;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state, descriptor pointer, captured element address and stop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            fl_addr_q <= '0;
            stop_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            if (state_q == ST_IDLE && uf_start_i) fl_addr_q <= fl_addr_i;
            if (state_q == ST_IDLE)               stop_q    <= 1'b0;
            else if (uf_end_i)                    stop_q    <= 1'b1;
        end
    end

    // R9: a waiting read keeps its request and address
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

    // R9: a waiting execute keeps its descriptor
    p_exec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid_o && !exec_done_i |=>
            exec_valid_o && $stable(exec_addr_o) && $stable(exec_async_o));

    // R9: memory and execute sides are never busy together
    p_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && exec_valid_o));

    // R2: a periodic micro-frame opens with a read of the built element address
    p_fl_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && uf_start_i && per_en_i |=>
            rd_req_o && rd_addr_o == $past(fl_addr_i));

    // R7: with the periodic list off the first step is the asynchronous head
    p_per_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && uf_start_i && !per_en_i && async_en_i && !head_term_i |=>
            exec_valid_o && exec_async_o && exec_addr_o == $past(head_addr_i));

    // R6: a terminated periodic pointer leads straight to an asynchronous descriptor
    p_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && !exec_async_o && state_q != ST_ASY_LINK && rd_term_i && !stop_now &&
        async_en_i && !head_term_i |=> exec_valid_o && exec_async_o);

    // R10: a stop at an execute boundary leaves nothing running
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fire && stop_now |=> !rd_req_o && !exec_valid_o);
endmodule

// File: rtl/sched_walker.sv
// Top of the micro-frame schedule walker: element address builder, two pointer
// decoders (read data and asynchronous head) and the walk sequencer.
// Assumes: IDX_W > PAGE_LSB + 1 so the index has unused bits above the field.
module sched_walker #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 14,
    parameter int PAGE_LSB   = 12,
    parameter int LINK_ALIGN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] per_base_i,
    input  logic [IDX_W-1:0]  frame_idx_i,
    input  logic              per_en_i,
    input  logic              async_en_i,
    input  logic [ADDR_W-1:0] async_head_i,
    input  logic              uframe_start_i,
    input  logic              uframe_end_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [ADDR_W-1:0] rd_data_i,
    output logic              exec_valid_o,
    output logic [ADDR_W-1:0] exec_addr_o,
    output logic              exec_async_o,
    input  logic              exec_done_i
);
    localparam int IDX_FIELD_W = PAGE_LSB - 2;

    logic [ADDR_W-1:0] fl_addr;
    logic              rd_term;
    logic [ADDR_W-1:0] rd_next;
    logic              head_term;
    logic [ADDR_W-1:0] head_addr;
    logic              cfg_unused;

    assign cfg_unused = ^{per_base_i[PAGE_LSB-1:0], frame_idx_i[2:0],
                          frame_idx_i[IDX_W-1:PAGE_LSB+1]};

    sched_fl_addr #(
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_fl_addr (
        .base_hi_i   (per_base_i[ADDR_W-1:PAGE_LSB]),
        .idx_field_i (frame_idx_i[IDX_FIELD_W+2:3]),
        .addr_o      (fl_addr)
    );

    sched_link_dec #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (LINK_ALIGN)
    ) u_rd_dec (
        .ptr_i  (rd_data_i),
        .term_o (rd_term),
        .addr_o (rd_next)
    );

    sched_link_dec #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (LINK_ALIGN)
    ) u_head_dec (
        .ptr_i  (async_head_i),
        .term_o (head_term),
        .addr_o (head_addr)
    );

    sched_walk_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .per_en_i     (per_en_i),
        .async_en_i   (async_en_i),
        .uf_start_i   (uframe_start_i),
        .uf_end_i     (uframe_end_i),
        .fl_addr_i    (fl_addr),
        .head_term_i  (head_term),
        .head_addr_i  (head_addr),
        .rd_valid_i   (rd_valid_i),
        .rd_term_i    (rd_term),
        .rd_next_i    (rd_next),
        .exec_done_i  (exec_done_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .exec_valid_o (exec_valid_o),
        .exec_addr_o  (exec_addr_o),
        .exec_async_o (exec_async_o)
    );
endmodule

// File: tb/sched_walker_bench.sv
// Directed bench for the schedule walker: memory and execute responders run
// on the falling edge, one task per scenario checks its own logs.
module sched_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] per_base_i;
    logic [13:0] frame_idx_i;
    logic        per_en_i;
    logic        async_en_i;
    logic [31:0] async_head_i;
    logic        uframe_start_i;
    logic        uframe_end_i;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_valid_i;
    logic [31:0] rd_data_i;
    logic        exec_valid_o;
    logic [31:0] exec_addr_o;
    logic        exec_async_o;
    logic        exec_done_i;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [0:63];
    logic [31:0] ex_log [0:63];
    logic        ex_asy [0:63];
    int rd_n = 0;
    int ex_n = 0;
    int rd_lat = 1;
    int ex_lat = 1;
    int rd_cnt = 0;
    int ex_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sched_walker u_sched_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .per_base_i     (per_base_i),
        .frame_idx_i    (frame_idx_i),
        .per_en_i       (per_en_i),
        .async_en_i     (async_en_i),
        .async_head_i   (async_head_i),
        .uframe_start_i (uframe_start_i),
        .uframe_end_i   (uframe_end_i),
        .rd_req_o       (rd_req_o),
        .rd_addr_o      (rd_addr_o),
        .rd_valid_i     (rd_valid_i),
        .rd_data_i      (rd_data_i),
        .exec_valid_o   (exec_valid_o),
        .exec_addr_o    (exec_addr_o),
        .exec_async_o   (exec_async_o),
        .exec_done_i    (exec_done_i)
    );

    // memory responder: answers a held request after rd_lat falling edges
    initial begin
        rd_valid_i = 1'b0;
        rd_data_i  = '0;
        forever begin
            @(negedge clk);
            if (rd_valid_i) begin
                rd_valid_i = 1'b0;
                rd_cnt     = 0;
            end else if (rd_req_o) begin
                if (rd_cnt >= rd_lat) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = mem.exists(rd_addr_o) ? mem[rd_addr_o] : 32'h1;
                    if (rd_n < 64) rd_log[rd_n] = rd_addr_o;
                    rd_n++;
                end else begin
                    rd_cnt++;
                end
            end else begin
                rd_cnt = 0;
            end
        end
    end

    // execute responder: finishes a presented descriptor after ex_lat falling edges
    initial begin
        exec_done_i = 1'b0;
        forever begin
            @(negedge clk);
            if (exec_done_i) begin
                exec_done_i = 1'b0;
                ex_cnt      = 0;
            end else if (exec_valid_o) begin
                if (ex_cnt >= ex_lat) begin
                    exec_done_i = 1'b1;
                    if (ex_n < 64) begin
                        ex_log[ex_n] = exec_addr_o;
                        ex_asy[ex_n] = exec_async_o;
                    end
                    ex_n++;
                end else begin
                    ex_cnt++;
                end
            end else begin
                ex_cnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_ex(input int i, input logic [31:0] a, input logic asy, input string req);
        chk(ex_log[i] == a, req, $sformatf("exec[%0d] addr", i), ex_log[i], a);
        chk(ex_asy[i] == asy, req, $sformatf("exec[%0d] list", i), 32'(ex_asy[i]), 32'(asy));
    endtask

    task automatic clear_logs();
        rd_n = 0;
        ex_n = 0;
        mem.delete();
    endtask

    task automatic pulse_start();
        @(negedge clk);
        uframe_start_i = 1'b1;
        @(negedge clk);
        uframe_start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (!rd_req_o && !exec_valid_o) quiet++;
            else quiet = 0;
        end
    endtask

    // shared list: three periodic descriptors (junk type bits) and two asynchronous
    task automatic load_chain();
        per_base_i   = 32'h0001_0000;
        frame_idx_i  = 14'h0058;
        async_head_i = 32'h0003_0000;
        mem[32'h0001_002C] = 32'h0002_0004;
        mem[32'h0002_0000] = 32'h0002_005E;
        mem[32'h0002_0040] = 32'h0002_0080;
        mem[32'h0002_0080] = 32'h0000_0001;
        mem[32'h0003_0000] = 32'h0003_0020;
        mem[32'h0003_0020] = 32'h0000_0021;
    endtask

    task automatic chk_chain(input string tag);
        chk(rd_n == 6, tag, "read count", 32'(rd_n), 32'd6);
        chk(ex_n == 5, tag, "exec count", 32'(ex_n), 32'd5);
        chk(rd_log[0] == 32'h0001_002C, "R2", "element address", rd_log[0], 32'h0001_002C);
        chk(rd_log[2] == 32'h0002_0040, "R5", "link read at descriptor", rd_log[2], 32'h0002_0040);
        chk_ex(0, 32'h0002_0000, 1'b0, "R5");
        chk_ex(1, 32'h0002_0040, 1'b0, "R5");
        chk_ex(2, 32'h0002_0080, 1'b0, "R4");
        chk_ex(3, 32'h0003_0000, 1'b1, "R6");
        chk_ex(4, 32'h0003_0020, 1'b1, "R8");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_req_o == 1'b0, "R1", "rd_req after reset", 32'(rd_req_o), 32'd0);
        chk(exec_valid_o == 1'b0, "R1", "exec_valid after reset", 32'(exec_valid_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R4 R5 R6 R8 R9: full periodic chain then asynchronous chain
    task automatic t_chain();
        logic [31:0] a;
        clear_logs();
        load_chain();
        per_en_i = 1'b1; async_en_i = 1'b1;
        rd_lat = 2; ex_lat = 3;
        pulse_start();
        while (!exec_valid_o) @(negedge clk);
        a = exec_addr_o;
        @(negedge clk);
        @(negedge clk);
        chk(exec_valid_o == 1'b1, "R9", "exec held", 32'(exec_valid_o), 32'd1);
        chk(exec_addr_o == a, "R9", "exec addr held", exec_addr_o, a);
        wait_idle();
        chk_chain("R4");
    endtask

    // R2: address building for several base/index pairs
    task automatic t_fl_addr();
        logic [31:0] bases [3] = '{32'h0001_0000, 32'hFFFF_FFFF, 32'hABCD_E123};
        logic [13:0] idxs  [3] = '{14'h0058, 14'h3FFF, 14'h2007};
        logic [31:0] exps  [3] = '{32'h0001_002C, 32'hFFFF_FFFC, 32'hABCD_E000};
        per_en_i = 1'b1; async_en_i = 1'b0;
        rd_lat = 0; ex_lat = 0;
        for (int k = 0; k < 3; k++) begin
            clear_logs();
            per_base_i  = bases[k];
            frame_idx_i = idxs[k];
            mem[exps[k]] = 32'h0000_0001;
            pulse_start();
            wait_idle();
            chk(rd_n == 1, "R2", "single element read", 32'(rd_n), 32'd1);
            chk(rd_log[0] == exps[k], "R2", "element address", rd_log[0], exps[k]);
            chk(ex_n == 0, "R8", "no exec, async off", 32'(ex_n), 32'd0);
        end
    endtask

    // R3: index change during a slow element read
    task automatic t_idx_hold();
        clear_logs();
        per_base_i = 32'h0001_0000; frame_idx_i = 14'h0058;
        per_en_i = 1'b1; async_en_i = 1'b0;
        mem[32'h0001_002C] = 32'h0000_0001;
        rd_lat = 6; ex_lat = 0;
        pulse_start();
        frame_idx_i = 14'h1FF8;
        @(negedge clk);
        chk(rd_addr_o == 32'h0001_002C, "R3", "address while waiting", rd_addr_o, 32'h0001_002C);
        wait_idle();
        chk(rd_log[0] == 32'h0001_002C, "R3", "address served", rd_log[0], 32'h0001_002C);
    endtask

    // R7: periodic list disabled
    task automatic t_per_off();
        clear_logs();
        load_chain();
        per_en_i = 1'b0; async_en_i = 1'b1;
        rd_lat = 1; ex_lat = 1;
        pulse_start();
        wait_idle();
        chk(ex_n == 2, "R7", "exec count", 32'(ex_n), 32'd2);
        chk_ex(0, 32'h0003_0000, 1'b1, "R7");
        chk(rd_n == 2, "R7", "read count", 32'(rd_n), 32'd2);
        chk(rd_log[0] == 32'h0003_0000, "R7", "no element read", rd_log[0], 32'h0003_0000);
    endtask

    // R8: asynchronous list disabled, then asynchronous head terminated
    task automatic t_async_off();
        clear_logs();
        load_chain();
        per_en_i = 1'b1; async_en_i = 1'b0;
        pulse_start();
        wait_idle();
        chk(ex_n == 3, "R8", "async off exec count", 32'(ex_n), 32'd3);
        chk(rd_n == 4, "R8", "async off read count", 32'(rd_n), 32'd4);
        clear_logs();
        load_chain();
        async_en_i = 1'b1;
        async_head_i = 32'h0003_0001;
        pulse_start();
        wait_idle();
        chk(ex_n == 3, "R8", "head term exec count", 32'(ex_n), 32'd3);
        chk(ex_asy[2] == 1'b0, "R8", "last is periodic", 32'(ex_asy[2]), 32'd0);
    endtask

    // R10: end strobe during an execute of a circular asynchronous list
    task automatic t_end_exec();
        int n0, r0;
        clear_logs();
        mem[32'h0004_0000] = 32'h0004_0020;
        mem[32'h0004_0020] = 32'h0004_0000;
        async_head_i = 32'h0004_0000;
        per_en_i = 1'b0; async_en_i = 1'b1;
        rd_lat = 1; ex_lat = 4;
        pulse_start();
        repeat (12) @(negedge clk);
        while (!exec_valid_o) @(negedge clk);
        n0 = ex_n; r0 = rd_n;
        uframe_end_i = 1'b1;
        @(negedge clk);
        uframe_end_i = 1'b0;
        chk(exec_valid_o == 1'b1, "R10", "exec completes", 32'(exec_valid_o), 32'd1);
        wait_idle();
        chk(ex_n == n0 + 1, "R10", "exec count after end", 32'(ex_n), 32'(n0 + 1));
        chk(rd_n == r0, "R10", "no link read after end", 32'(rd_n), 32'(r0));
    endtask

    // R10: end strobe during a link read
    task automatic t_end_read();
        int n0, r0;
        clear_logs();
        mem[32'h0004_0000] = 32'h0004_0020;
        mem[32'h0004_0020] = 32'h0004_0000;
        rd_lat = 5; ex_lat = 0;
        pulse_start();
        while (!rd_req_o) @(negedge clk);
        n0 = ex_n; r0 = rd_n;
        uframe_end_i = 1'b1;
        @(negedge clk);
        uframe_end_i = 1'b0;
        chk(rd_req_o == 1'b1, "R10", "read completes", 32'(rd_req_o), 32'd1);
        wait_idle();
        chk(ex_n == n0, "R10", "no exec after end", 32'(ex_n), 32'(n0));
        chk(rd_n == r0 + 1, "R10", "read count after end", 32'(rd_n), 32'(r0 + 1));
    endtask

    // R11: a second start in mid-walk changes nothing
    task automatic t_busy_start();
        clear_logs();
        load_chain();
        per_en_i = 1'b1; async_en_i = 1'b1;
        rd_lat = 3; ex_lat = 1;
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        wait_idle();
        chk_chain("R11");
    endtask

    // R1: reset in mid-walk returns to idle
    task automatic t_reset_busy();
        clear_logs();
        mem[32'h0004_0000] = 32'h0004_0020;
        mem[32'h0004_0020] = 32'h0004_0000;
        async_head_i = 32'h0004_0000;
        per_en_i = 1'b0; async_en_i = 1'b1;
        rd_lat = 2; ex_lat = 2;
        pulse_start();
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!rd_req_o && !exec_valid_o, "R1", "idle after mid-walk reset",
            32'({rd_req_o, exec_valid_o}), 32'd0);
        rst_n = 1'b1;
        wait_idle();
    endtask

    initial begin
        per_base_i = '0; frame_idx_i = '0; per_en_i = 1'b0; async_en_i = 1'b0;
        async_head_i = 32'h1; uframe_start_i = 1'b0; uframe_end_i = 1'b0;
        t_reset();
        t_chain();
        t_fl_addr();
        t_idx_hold();
        t_per_off();
        t_async_off();
        t_end_exec();
        t_end_read();
        t_busy_start();
        t_reset_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule